// File: doc/BRIEF.md
# Shadow Instruction Operand Remapper

This block turns an instruction word into its shadow copy for self-checking by duplicated execution. The shadow copy uses the upper half of the register file and its own slice of the data address space, so the original and the copy can run side by side without touching each other's state. The block is purely combinational. It classifies the 32-bit word by its 7-bit major opcode into four recognised formats: register-register ALU, register-immediate ALU, load and store. For each format it rebuilds a candidate word from that format's fields, using remapped values where they apply. A fixed-order selection chain then picks the candidate for the recognised format. A word in any other format leaves the block unchanged.

Two enables control the remapping. With `halfRegEn` set, every non-zero register index gets its top bit forced to 1. Register zero is never moved. With `halfMemEn` set, the 12-bit address offset of loads and stores gets its top two bits replaced by binary 01. Immediates in formats that do not access memory are never altered.

Top module: `shadowRemap`

## Requirements
- R1: A register field (rd at [11:7], rs1 at [19:15], rs2 at [24:20]) that holds 0 is output as 0 in every mode.
- R2: With halfRegEn=1, every non-zero register field used by a recognised format is output with bit 4 set and bits 3:0 unchanged. rd, rs1 and rs2 are used by opcode 0110011. rd and rs1 are used by opcodes 0010011 and 0000011. rs1 and rs2 are used by opcode 0100011.
- R3: With halfRegEn=0, register fields leave the block unchanged.
- R4: With halfMemEn=1, a load (opcode 0000011) has its offset [31:20] output as {2'b01, original [29:20]}.
- R5: With halfMemEn=1, a store (opcode 0100011) has bits [31:30] output as 01. Bits [29:25] and [11:7], the rest of its split offset, are kept.
- R6: The immediate [31:20] of a register-immediate ALU word (opcode 0010011) is never remapped, even with halfMemEn=1.
- R7: With halfMemEn=0, load and store offsets leave the block unchanged.
- R8: Bit ranges that the format does not use as register fields are not register-remapped. This covers [24:20] of opcodes 0010011 and 0000011, and [11:7] of opcode 0100011.
- R9: A word whose opcode [6:0] is not one of the four recognised values is output unchanged, whatever the enables.
- R10: The opcode [6:0] and function bits [14:12] are always kept. Bits [31:25] of opcode 0110011 are also always kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instrIn | input | 32 | Original instruction word |
| halfRegEn | input | 1 | Enables moving register indices into the upper half |
| halfMemEn | input | 1 | Enables moving load/store offsets into the shadow address slice |
| instrOut | output | 32 | Shadow instruction word |

## Verification
The in-design checks assume that the opcode classification never flags more than one format at a time. Stimulus satisfies this by construction, because every word carries exactly one opcode value. The checks also assume that inputs are stable when sampled. The bench therefore drives on the falling clock edge and compares half a period later. Random words are drawn per format, with an extra share of unrecognised opcodes and of words whose register fields are zero. Directed words cover all-zero and all-one fields under each of the four enable combinations.

// File: rtl/shadow_remap_pkg.sv
package shadow_remap_pkg;
  localparam int unsigned INSTR_W   = 32;
  localparam int unsigned OPC_W     = 7;
  localparam int unsigned REG_IDX_W = 5;
  localparam int unsigned PREFIX_W  = 2;
  localparam int unsigned NUM_REGF  = 3;

  localparam logic [OPC_W-1:0] OPC_REG3  = 7'b0110011;
  localparam logic [OPC_W-1:0] OPC_REGIM = 7'b0010011;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 7'b0000011;
  localparam logic [OPC_W-1:0] OPC_STORE = 7'b0100011;

  localparam logic [PREFIX_W-1:0] MEM_PREFIX = 2'b01;

  // strobes from control to datapath
  typedef struct packed {
    logic selReg3;
    logic selRegIm;
    logic selLoad;
    logic selStore;
    logic regRemap;
    logic memRemap;
  } remapCtrl_t;
endpackage

// File: rtl/regFieldMap.sv
module regFieldMap #(
  parameter int unsigned W = 5
) (
  input  logic         enable,
  input  logic [W-1:0] fieldIn,
  output logic [W-1:0] fieldOut
);
  logic isZero;

  always_comb begin
    isZero = (fieldIn == '0);
    if (enable && !isZero) fieldOut = {1'b1, fieldIn[W-2:0]};
    else                   fieldOut = fieldIn;
  end

  always_comb begin
    // R1
    zero_reg_kept_chk: assert (!isZero || fieldOut == '0);
    // R2
    low_bits_kept_chk: assert (fieldOut[W-2:0] == fieldIn[W-2:0]);
    // R3
    disabled_pass_chk: assert (enable || fieldOut == fieldIn);
  end
endmodule

// File: rtl/remapControl.sv
module remapControl
  import shadow_remap_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  input  logic             halfRegEn,
  input  logic             halfMemEn,
  output remapCtrl_t       ctrl
);
  always_comb begin
    ctrl.selReg3  = (opcode == OPC_REG3);
    ctrl.selRegIm = (opcode == OPC_REGIM);
    ctrl.selLoad  = (opcode == OPC_LOAD);
    ctrl.selStore = (opcode == OPC_STORE);
    ctrl.regRemap = halfRegEn;
    ctrl.memRemap = halfMemEn;
  end

  always_comb begin
    // R9
    single_format_chk: assert ($onehot0({ctrl.selReg3, ctrl.selRegIm,
                                         ctrl.selLoad, ctrl.selStore}));
  end
endmodule

// File: rtl/remapDatapath.sv
module remapDatapath
  import shadow_remap_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  input  remapCtrl_t         ctrl,
  output logic [INSTR_W-1:0] instrOut
);
  localparam int unsigned REGF_LSB [NUM_REGF] = '{7, 15, 20};
  localparam int unsigned IMM_W    = 12;
  localparam int unsigned STHI_W   = 7;

  logic [REG_IDX_W-1:0] regOrig [NUM_REGF];
  logic [REG_IDX_W-1:0] regNew  [NUM_REGF];

  for (genvar g = 0; g < NUM_REGF; g++) begin : gRegMap
    assign regOrig[g] = instr[REGF_LSB[g] +: REG_IDX_W];
    regFieldMap #(.W(REG_IDX_W)) uMap (
      .enable  (ctrl.regRemap),
      .fieldIn (regOrig[g]),
      .fieldOut(regNew[g])
    );
  end

  logic [IMM_W-1:0]   loadImm;
  logic [STHI_W-1:0]  storeHi;
  logic [INSTR_W-1:0] candReg3, candRegIm, candLoad, candStore;

  always_comb begin
    loadImm = ctrl.memRemap ? {MEM_PREFIX, instr[29:20]} : instr[31:20];
    storeHi = ctrl.memRemap ? {MEM_PREFIX, instr[29:25]} : instr[31:25];

    candReg3  = {instr[31:25], regNew[2], regNew[1], instr[14:12], regNew[0], instr[6:0]};
    candRegIm = {instr[31:20], regNew[1], instr[14:12], regNew[0], instr[6:0]};
    candLoad  = {loadImm, regNew[1], instr[14:12], regNew[0], instr[6:0]};
    candStore = {storeHi, regNew[2], regNew[1], instr[14:12], instr[11:7], instr[6:0]};

    if (ctrl.selReg3)       instrOut = candReg3;
    else if (ctrl.selRegIm) instrOut = candRegIm;
    else if (ctrl.selLoad)  instrOut = candLoad;
    else if (ctrl.selStore) instrOut = candStore;
    else                    instrOut = instr;
  end

  always_comb begin
    // R10
    opcode_kept_chk: assert (instrOut[6:0] == instr[6:0] && instrOut[14:12] == instr[14:12]);
    // R9
    passthru_chk: assert ((ctrl.selReg3 | ctrl.selRegIm | ctrl.selLoad | ctrl.selStore)
                          || instrOut == instr);
    // R6
    imm_untouched_chk: assert (!ctrl.selRegIm || instrOut[31:20] == instr[31:20]);
    // R4
    load_prefix_chk: assert (!(ctrl.selLoad && ctrl.memRemap) || instrOut[31:30] == MEM_PREFIX);
    // R5
    store_prefix_chk: assert (!(ctrl.selStore && ctrl.memRemap)
                              || (instrOut[31:30] == MEM_PREFIX && instrOut[11:7] == instr[11:7]));
  end
endmodule

// File: rtl/shadowRemap.sv
module shadowRemap
  import shadow_remap_pkg::*;
(
  input  logic [31:0] instrIn,
  input  logic        halfRegEn,
  input  logic        halfMemEn,
  output logic [31:0] instrOut
);
  remapCtrl_t ctrl;

  remapControl uCtrl (
    .opcode   (instrIn[OPC_W-1:0]),
    .halfRegEn(halfRegEn),
    .halfMemEn(halfMemEn),
    .ctrl     (ctrl)
  );

  remapDatapath uDp (
    .instr   (instrIn),
    .ctrl    (ctrl),
    .instrOut(instrOut)
  );
endmodule

// File: tb/tb_shadowRemap.sv
module tb_shadowRemap;
  logic clk = 0;
  always #10 clk = ~clk;   // 50 MHz

  logic [31:0] instrIn = '0;
  logic        halfRegEn = 0, halfMemEn = 0;
  logic [31:0] instrOut;

  int checks = 0, errors = 0;
  bit done = 0;

  shadowRemap dut (.instrIn(instrIn), .halfRegEn(halfRegEn),
                   .halfMemEn(halfMemEn), .instrOut(instrOut));

  function automatic logic [4:0] mapReg(logic [4:0] r, logic en);
    if (en && r != 5'd0) return r | 5'b10000;
    return r;
  endfunction

  function automatic logic [31:0] model(logic [31:0] w, logic hr, logic hm);
    logic [31:0] e;
    e = w;
    case (w[6:0])
      7'b0110011: begin
        e[11:7] = mapReg(w[11:7], hr); e[19:15] = mapReg(w[19:15], hr);
        e[24:20] = mapReg(w[24:20], hr);
      end
      7'b0010011: begin
        e[11:7] = mapReg(w[11:7], hr); e[19:15] = mapReg(w[19:15], hr);
      end
      7'b0000011: begin
        e[11:7] = mapReg(w[11:7], hr); e[19:15] = mapReg(w[19:15], hr);
        if (hm) e[31:30] = 2'b01;
      end
      7'b0100011: begin
        e[19:15] = mapReg(w[19:15], hr); e[24:20] = mapReg(w[24:20], hr);
        if (hm) e[31:30] = 2'b01;
      end
      default: ;
    endcase
    return e;
  endfunction

  function automatic string tagFor(logic [31:0] w, logic hr, logic hm);
    case (w[6:0])
      7'b0110011: return hr ? "R2/R10" : "R3/R10";
      7'b0010011: return hr ? "R2/R6/R8" : "R3/R6";
      7'b0000011: return hm ? "R4/R8" : "R7/R1";
      7'b0100011: return hm ? "R5/R8" : "R7/R3";
      default:    return "R9";
    endcase
  endfunction

  task automatic apply(logic [31:0] w, logic hr, logic hm, string tag);
    logic [31:0] exp;
    @(negedge clk);
    instrIn = w; halfRegEn = hr; halfMemEn = hm;
    @(posedge clk);
    exp = model(w, hr, hm);
    checks++;
    if (instrOut !== exp) begin
      errors++;
      $display("FAIL %s: in=%h hr=%0b hm=%0b actual=%h expected=%h",
               tag, w, hr, hm, instrOut, exp);
    end
  endtask

  task automatic finish();
    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish();
  end

  initial begin
    logic [6:0] opcs [5];
    void'($urandom(32'd20240611));
    opcs[0] = 7'b0110011; opcs[1] = 7'b0010011; opcs[2] = 7'b0000011;
    opcs[3] = 7'b0100011; opcs[4] = 7'b1100011;
    // idle word: opcode 0 not recognised (R9)
    apply(32'h0, 1, 1, "R9");
    for (int m = 0; m < 4; m++) begin
      logic hr, hm;
      hr = m[0]; hm = m[1];
      for (int k = 0; k < 4; k++) begin
        // all-zero register fields (R1), all-one fields (R2)
        apply({25'h0, opcs[k]}, hr, hm, "R1");
        apply({25'h1FFFFFF, opcs[k]}, hr, hm, tagFor({25'h1FFFFFF, opcs[k]}, hr, hm));
        apply({25'h0AAAAAA, opcs[k]}, hr, hm, tagFor({25'h0AAAAAA, opcs[k]}, hr, hm));
      end
      apply({25'h1FFFFFF, 7'b1101111}, hr, hm, "R9");
    end
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] w;
      int sel;
      w = $urandom;
      sel = $urandom_range(0, 5);
      if (sel < 5) w[6:0] = opcs[sel];
      if ($urandom_range(0, 3) == 0) begin
        w[11:7] = 5'd0; w[19:15] = 5'd0; w[24:20] = 5'd0;
      end
      apply(w, 1'($urandom), 1'($urandom), tagFor(w, 1'b1, 1'b1));
    end
    finish();
  end
endmodule